// File: doc/BRIEF.md
# Configurable Sum-of-Products Register Cell

This block is one storage slice of a programmable sum-of-products logic device. The surrounding AND/OR array delivers four sum terms, a per-cell reset term and a per-cell preset term. The slice combines these with global clock, reset and preset lines. Static configuration inputs decide how the single storage bit behaves. It can work as a D flip-flop, a toggle flip-flop or a JK flip-flop. The cell clock comes from a sum term or from one of the global clocks, and it acts on either edge. Reset and preset each come from the per-cell term or from the global line.

The whole slice runs in one fast system clock domain, which keeps it usable inside an FPGA fabric. The selected cell clock is treated as a sampled level. An effective edge is a low-to-high change of that level after the polarity inversion, seen between two system clock edges. Reset and preset do not wait for a cell clock edge. They take effect at the next system clock edge. The slice has two outputs: the stored bit, and a second function that is either the raw combinatorial sum term C or the stored bit.

Top module: `pld_logic_cell`

## Requirements
- R1: While `rst` is high at a system clock edge, `q_out` becomes 0. After reset, the first cell update needs a genuine low-to-high change of the effective cell clock that happens after reset is released.
- R2: With `cfg_kind` = 0 (D), an effective cell clock edge loads `sum_term[0]` (term A) into `q_out`.
- R3: With `cfg_kind` = 1 (T), an effective cell clock edge inverts `q_out` when term A is 1. The edge leaves `q_out` unchanged when term A is 0.
- R4: With `cfg_kind` = 2 (JK), term A is J and `sum_term[1]` (term B) is K. On an effective edge: J=0,K=0 holds; J=1,K=0 sets; J=0,K=1 clears; J=1,K=1 inverts.
- R5: `cfg_clk_src` picks the cell clock: 0 = `sum_term[3]` (term D), 1 = `gclk[0]`, 2 = `gclk[1]`. Transitions on sources that are not selected do not change `q_out`.
- R6: With `cfg_clk_fall` = 0 the cell updates on a rising change of the selected source. With `cfg_clk_fall` = 1 it updates on a falling change. `q_out` changes at the same system clock edge at which the new source level is first sampled.
- R7: `cfg_rst_global` = 0 selects `pt_rst` as the reset source, and 1 selects `grst`. An active selected reset clears `q_out` at the next system edge without any cell clock edge. The unselected reset line has no effect.
- R8: `cfg_pre_global` = 0 selects `pt_pre` as the preset source, and 1 selects `gpre`. An active selected preset sets `q_out` at the next system edge without a cell clock edge. The unselected preset line has no effect.
- R9: When the selected reset and the selected preset are both active, reset wins and `q_out` becomes 0. Either of them overrides a simultaneous cell clock edge.
- R10: With `cfg_out2_reg` = 0, `f_out` follows `sum_term[2]` (term C) combinatorially. With `cfg_out2_reg` = 1, `f_out` equals `q_out`.
- R11: `cfg_kind` = 3 behaves exactly as D mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| sum_term | input | 4 | Sum terms A (bit 0), B (bit 1), C (bit 2), D (bit 3) |
| pt_rst | input | 1 | Per-cell reset term |
| pt_pre | input | 1 | Per-cell preset term |
| gclk | input | NUM_GCLK | Global clock levels |
| grst | input | 1 | Global reset |
| gpre | input | 1 | Global preset |
| cfg_kind | input | 2 | Storage kind: 0 D, 1 T, 2 JK, 3 D |
| cfg_clk_src | input | $clog2(NUM_GCLK+1) | Cell clock source select |
| cfg_clk_fall | input | 1 | 1 = update on falling change of the source |
| cfg_rst_global | input | 1 | 1 = reset from `grst` |
| cfg_pre_global | input | 1 | 1 = preset from `gpre` |
| cfg_out2_reg | input | 1 | 1 = second output carries the stored bit |
| q_out | output | 1 | Stored bit |
| f_out | output | 1 | Second output function |

## Verification
Three things can land on the same system clock edge: a cell clock edge, the selected reset and the selected preset. Their priority is the point most likely to go wrong. Directed steps drive the per-cell reset and the global preset together. A randomized sweep then raises both override sources about one cycle in eight, while the clock levels and sum terms are also random. A behavioural reference model in the bench applies reset over preset over edge on every cycle, and `q_out` and `f_out` are compared against it on every cycle across all kinds, clock sources and polarities.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  typedef enum logic [1:0] {
    KIND_D   = 2'd0,
    KIND_T   = 2'd1,
    KIND_JK  = 2'd2,
    KIND_ALT = 2'd3
  } reg_kind_e;

  localparam int SUM_TERMS = 4;
  localparam int TERM_A    = 0;
  localparam int TERM_B    = 1;
  localparam int TERM_C    = 2;
  localparam int TERM_D    = 3;
endpackage

// File: rtl/pld_clk_sel.sv
module pld_clk_sel #(
  parameter int NUM_GCLK = 2,
  parameter int CSEL_W   = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                term_clk,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [CSEL_W-1:0]   src_sel,
  input  logic                fall,
  output logic                edge_pulse
);
  localparam int NUM_SRC = NUM_GCLK + 1;

  logic [NUM_SRC-1:0] cand;
  logic               lvl;
  logic               eff;
  logic               prev_q;

  assign cand[0] = term_clk;
  for (genvar g = 0; g < NUM_GCLK; g++) begin : g_src
    assign cand[g+1] = gclk[g];
  end

  always_comb begin
    lvl = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (int'(src_sel) == s) lvl = cand[s];
    end
  end

  assign eff = lvl ^ fall;

  // After reset the previous level is taken as high, so a source that is
  // already high does not count as an edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= eff;
  end

  assign edge_pulse = eff & ~prev_q & ~rst;
endmodule

// File: rtl/pld_set_reset.sv
module pld_set_reset (
  input  logic pt_rst,
  input  logic pt_pre,
  input  logic grst,
  input  logic gpre,
  input  logic sel_rst_global,
  input  logic sel_pre_global,
  output logic clr,
  output logic set
);
  assign clr = sel_rst_global ? grst : pt_rst;
  assign set = sel_pre_global ? gpre : pt_pre;
endmodule

// File: rtl/pld_next_state.sv
module pld_next_state
  import pld_cell_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       a,
  input  logic       b,
  input  logic       q,
  output logic       nxt
);
  always_comb begin
    unique case (reg_kind_e'(kind))
      KIND_T:  nxt = q ^ a;
      KIND_JK: nxt = (a & ~q) | (~b & q);
      default: nxt = a;
    endcase
  end
endmodule

// File: rtl/pld_logic_cell.sv
module pld_logic_cell
  import pld_cell_pkg::*;
#(
  parameter int NUM_GCLK = 2,
  localparam int CSEL_W  = $clog2(NUM_GCLK + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SUM_TERMS-1:0] sum_term,
  input  logic                 pt_rst,
  input  logic                 pt_pre,
  input  logic [NUM_GCLK-1:0]  gclk,
  input  logic                 grst,
  input  logic                 gpre,
  input  logic [1:0]           cfg_kind,
  input  logic [CSEL_W-1:0]    cfg_clk_src,
  input  logic                 cfg_clk_fall,
  input  logic                 cfg_rst_global,
  input  logic                 cfg_pre_global,
  input  logic                 cfg_out2_reg,
  output logic                 q_out,
  output logic                 f_out
);
  logic clk_edge;
  logic ctl_clr;
  logic ctl_set;
  logic nxt_q;
  logic q_r;

  pld_clk_sel #(.NUM_GCLK(NUM_GCLK), .CSEL_W(CSEL_W)) u_clk_sel (
    .clk        (clk),
    .rst        (rst),
    .term_clk   (sum_term[TERM_D]),
    .gclk       (gclk),
    .src_sel    (cfg_clk_src),
    .fall       (cfg_clk_fall),
    .edge_pulse (clk_edge)
  );

  pld_set_reset u_set_reset (
    .pt_rst         (pt_rst),
    .pt_pre         (pt_pre),
    .grst           (grst),
    .gpre           (gpre),
    .sel_rst_global (cfg_rst_global),
    .sel_pre_global (cfg_pre_global),
    .clr            (ctl_clr),
    .set            (ctl_set)
  );

  pld_next_state u_next (
    .kind (cfg_kind),
    .a    (sum_term[TERM_A]),
    .b    (sum_term[TERM_B]),
    .q    (q_r),
    .nxt  (nxt_q)
  );

  always_ff @(posedge clk) begin
    if (rst)           q_r <= 1'b0;
    else if (ctl_clr)  q_r <= 1'b0;
    else if (ctl_set)  q_r <= 1'b1;
    else if (clk_edge) q_r <= nxt_q;
  end

  assign q_out = q_r;
  assign f_out = cfg_out2_reg ? q_r : sum_term[TERM_C];
endmodule

// File: rtl/pld_logic_cell_chk.sv
module pld_logic_cell_chk #(
  parameter int NUM_GCLK = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] sum_term,
  input logic       pt_rst,
  input logic       pt_pre,
  input logic       grst,
  input logic       gpre,
  input logic [1:0] cfg_kind,
  input logic       cfg_rst_global,
  input logic       cfg_pre_global,
  input logic       clk_edge,
  input logic       q_out
);
  logic rs;
  logic ps;
  assign rs = cfg_rst_global ? grst : pt_rst;
  assign ps = cfg_pre_global ? gpre : pt_pre;

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !q_out);

  assert_d_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_edge && !rs && !ps && cfg_kind == 2'd0) |=> q_out == $past(sum_term[0]));

  assert_t_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (clk_edge && !rs && !ps && cfg_kind == 2'd1 && !sum_term[0]) |=> $stable(q_out));

  assert_jk_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    (clk_edge && !rs && !ps && cfg_kind == 2'd2 && sum_term[0] && sum_term[1])
    |=> q_out != $past(q_out));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!clk_edge && !rs && !ps) |=> $stable(q_out));

  assert_preset_R8: assert property (@(posedge clk) disable iff (rst)
    (!rs && ps) |=> q_out);

  assert_reset_wins_R9: assert property (@(posedge clk) disable iff (rst)
    rs |=> !q_out);
endmodule

bind pld_logic_cell pld_logic_cell_chk #(.NUM_GCLK(NUM_GCLK)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .sum_term       (sum_term),
  .pt_rst         (pt_rst),
  .pt_pre         (pt_pre),
  .grst           (grst),
  .gpre           (gpre),
  .cfg_kind       (cfg_kind),
  .cfg_rst_global (cfg_rst_global),
  .cfg_pre_global (cfg_pre_global),
  .clk_edge       (clk_edge),
  .q_out          (q_out)
);

// File: tb/pld_logic_cell_bench.sv
module pld_logic_cell_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sum_term = 4'd0;
  logic       pt_rst = 1'b0;
  logic       pt_pre = 1'b0;
  logic [1:0] gclk = 2'd0;
  logic       grst = 1'b0;
  logic       gpre = 1'b0;
  logic [1:0] cfg_kind = 2'd0;
  logic [1:0] cfg_clk_src = 2'd1;
  logic       cfg_clk_fall = 1'b0;
  logic       cfg_rst_global = 1'b0;
  logic       cfg_pre_global = 1'b0;
  logic       cfg_out2_reg = 1'b0;
  logic       q_out;
  logic       f_out;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  logic m_q = 1'b0;
  logic m_prev = 1'b1;

  always #4 clk = ~clk;

  pld_logic_cell #(.NUM_GCLK(2)) u_pld_logic_cell (
    .clk(clk), .rst(rst), .sum_term(sum_term), .pt_rst(pt_rst), .pt_pre(pt_pre),
    .gclk(gclk), .grst(grst), .gpre(gpre), .cfg_kind(cfg_kind),
    .cfg_clk_src(cfg_clk_src), .cfg_clk_fall(cfg_clk_fall),
    .cfg_rst_global(cfg_rst_global), .cfg_pre_global(cfg_pre_global),
    .cfg_out2_reg(cfg_out2_reg), .q_out(q_out), .f_out(f_out)
  );

  // Behavioural reference: reset over preset over clock edge.
  always @(posedge clk) begin
    logic lvl;
    logic r_src;
    logic p_src;
    case (cfg_clk_src)
      2'd0:    lvl = sum_term[3];
      2'd1:    lvl = gclk[0];
      2'd2:    lvl = gclk[1];
      default: lvl = 1'b0;
    endcase
    if (cfg_clk_fall) lvl = !lvl;
    r_src = cfg_rst_global ? grst : pt_rst;
    p_src = cfg_pre_global ? gpre : pt_pre;
    if (rst) begin
      m_q = 1'b0;
      m_prev = 1'b1;
    end else begin
      if (r_src) m_q = 1'b0;
      else if (p_src) m_q = 1'b1;
      else if (lvl && !m_prev) begin
        if (cfg_kind == 2'd1) begin
          if (sum_term[0]) m_q = !m_q;
        end else if (cfg_kind == 2'd2) begin
          if (sum_term[0] && sum_term[1]) m_q = !m_q;
          else if (sum_term[0]) m_q = 1'b1;
          else if (sum_term[1]) m_q = 1'b0;
        end else begin
          m_q = sum_term[0];
        end
      end
      m_prev = lvl;
    end
    started = 1'b1;
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check(q_out, m_q, cur_req, "model q_out");
      check(f_out, cfg_out2_reg ? m_q : sum_term[2], cur_req, "model f_out");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic term_pulse();
    sum_term[3] = 1'b0; cyc(1);
    sum_term[3] = 1'b1; cyc(1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    check(q_out, 1'b0, "R1", "reset state");
    rst = 1'b0;
    cyc(1);

    cur_req = "R2";
    cfg_kind = 2'd0; cfg_clk_src = 2'd1; cfg_clk_fall = 1'b0;
    sum_term[0] = 1'b1; cyc(2);
    check(q_out, 1'b0, "R5", "no edge yet");
    gclk[0] = 1'b1; cyc(1);
    check(q_out, 1'b1, "R2", "D capture 1");
    sum_term[0] = 1'b0;
    cur_req = "R5";
    gclk[1] = 1'b1; cyc(1); gclk[1] = 1'b0; cyc(1);
    check(q_out, 1'b1, "R5", "unselected gclk ignored");
    cur_req = "R2";
    gclk[0] = 1'b0; cyc(1); gclk[0] = 1'b1; cyc(1);
    check(q_out, 1'b0, "R2", "D capture 0");

    cur_req = "R6";
    cfg_clk_fall = 1'b1; sum_term[0] = 1'b1; cyc(1);
    check(q_out, 1'b0, "R6", "polarity switch no edge");
    gclk[0] = 1'b0; cyc(1);
    check(q_out, 1'b1, "R6", "falling update");
    sum_term[0] = 1'b0; gclk[0] = 1'b1; cyc(1);
    check(q_out, 1'b1, "R6", "rising ignored in fall mode");

    cur_req = "R3";
    cfg_clk_src = 2'd0; cfg_clk_fall = 1'b0; sum_term[3] = 1'b0; cyc(1);
    cfg_kind = 2'd1; sum_term[0] = 1'b1;
    term_pulse();
    check(q_out, 1'b0, "R3", "toggle to 0");
    term_pulse();
    check(q_out, 1'b1, "R3", "toggle to 1");
    sum_term[0] = 1'b0;
    term_pulse();
    check(q_out, 1'b1, "R3", "T hold");

    cur_req = "R4";
    cfg_kind = 2'd2;
    sum_term[1:0] = 2'b10; term_pulse();
    check(q_out, 1'b0, "R4", "JK clear");
    sum_term[1:0] = 2'b01; term_pulse();
    check(q_out, 1'b1, "R4", "JK set");
    sum_term[1:0] = 2'b00; term_pulse();
    check(q_out, 1'b1, "R4", "JK hold");
    sum_term[1:0] = 2'b11; term_pulse();
    check(q_out, 1'b0, "R4", "JK toggle a");
    term_pulse();
    check(q_out, 1'b1, "R4", "JK toggle b");

    cur_req = "R11";
    cfg_kind = 2'd3; sum_term[1:0] = 2'b00; term_pulse();
    check(q_out, 1'b0, "R11", "kind 3 loads 0");
    sum_term[0] = 1'b1; term_pulse();
    check(q_out, 1'b1, "R11", "kind 3 loads 1");

    cur_req = "R7";
    cfg_rst_global = 1'b0; grst = 1'b1; cyc(1);
    check(q_out, 1'b1, "R7", "unselected grst ignored");
    grst = 1'b0; pt_rst = 1'b1; cyc(1);
    check(q_out, 1'b0, "R7", "per-cell reset");
    pt_rst = 1'b0; cyc(1);

    cur_req = "R8";
    cfg_pre_global = 1'b1; pt_pre = 1'b1; cyc(1);
    check(q_out, 1'b0, "R8", "unselected pt_pre ignored");
    pt_pre = 1'b0; gpre = 1'b1; cyc(1);
    check(q_out, 1'b1, "R8", "global preset");

    cur_req = "R9";
    pt_rst = 1'b1; cyc(1);
    check(q_out, 1'b0, "R9", "reset beats preset");
    pt_rst = 1'b0; gpre = 1'b0; cyc(1);

    cur_req = "R10";
    cfg_out2_reg = 1'b0; sum_term[2] = 1'b1; #1;
    check(f_out, 1'b1, "R10", "f_out term C high");
    sum_term[2] = 1'b0; #1;
    check(f_out, 1'b0, "R10", "f_out term C low");
    cfg_out2_reg = 1'b1; sum_term[2] = 1'b1; #1;
    check(f_out, q_out, "R10", "f_out follows q");
    cyc(1);

    for (int cfg = 0; cfg < 24; cfg++) begin
      cfg_kind = 2'(cfg % 4);
      cfg_clk_src = 2'((cfg / 4) % 3);
      cfg_clk_fall = 1'((cfg / 12) % 2);
      cfg_rst_global = 1'(cfg % 2);
      cfg_pre_global = 1'((cfg / 2) % 2);
      cfg_out2_reg = 1'((cfg / 3) % 2);
      case (cfg % 4)
        0: cur_req = "R2";
        1: cur_req = "R3";
        2: cur_req = "R4";
        default: cur_req = "R11";
      endcase
      for (int k = 0; k < 60; k++) begin
        sum_term = 4'($urandom_range(0, 15));
        gclk = 2'($urandom_range(0, 3));
        pt_rst = ($urandom_range(0, 7) == 0);
        grst = ($urandom_range(0, 7) == 0);
        pt_pre = ($urandom_range(0, 7) == 0);
        gpre = ($urandom_range(0, 7) == 0);
        cyc(1);
      end
    end

    cur_req = "R1";
    rst = 1'b1; cyc(2);
    check(q_out, 1'b0, "R1", "reset after sweep");
    cyc(1);
    finish_run();
  end
endmodule